// File: doc/BRIEF.md
# UART Transmit Path with Channel Test Routing

This block is the serial transmit side of a UART. A character written through a one-byte strobe interface first lands in a holding register. From there it moves into a shift register, which sends it as an 8N1 frame paced by an external baud tick. Two status bits report the state of the path. One says the holding register can take another character. The other says the whole path, including the stop bit of the last frame, has finished.

A two-bit channel mode selects how the serial lines are routed:

- **Normal operation:** the transmitter drives the pin and the receive pin feeds the receiver.
- **Automatic echo:** the receive pin is repeated onto the transmit pin.
- **Local loopback:** the transmitter is turned back into the receiver, and the transmit pin idles high.
- **Remote loopback:** the receive pin is wired straight to the transmit pin, and the transmit path is frozen.

The receiver itself, the baud generator and any register interface live outside this block.

Top module: `uart_tx_chan`

## Requirements
- R1: After reset, tx_pin is 1, tx_ready is 1 and tx_empty is 1.
- R2: A write with the holding register empty and the shifter idle drops tx_ready for exactly one clock. The frame's start bit appears on the transmitter line in the clock after that write, and tx_ready is back at 1 in that same clock.
- R3: A frame is a 0 start bit, then the 8 data bits with bit 0 first, then a 1 stop bit. Each bit lasts 16 baud ticks. With no frame in progress, the transmitter line is 1.
- R4: A write made while a frame is shifting keeps tx_ready at 0 until that frame's stop bit ends. The pending character starts its frame one clock after the stop bit ends.
- R5: A write made while the holding register is already full replaces the pending character, and tx_ready stays 0.
- R6: tx_empty is 1 only when the holding register and the shifter are both empty. It rises in the clock after the 16th tick of the last stop bit.
- R7: In mode 00 (normal), tx_pin carries the transmitter line and rx_feed carries rx_pin.
- R8: In mode 01 (automatic echo), tx_pin and rx_feed both follow rx_pin combinationally. The transmitter keeps running and its flags keep changing.
- R9: In mode 10 (local loopback), rx_feed carries the transmitter line and tx_pin is held at 1. rx_pin has no effect on either output.
- R10: In mode 11 (remote loopback), tx_pin follows rx_pin and rx_feed is held at 1. Writes are ignored, the transmitter's progress stops, and tx_ready and tx_empty keep their values. Leaving mode 11 resumes the frame where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to send |
| chan_mode | input | 2 | Channel routing: 00 normal, 01 echo, 10 local loopback, 11 remote loopback |
| baud_tick | input | 1 | One pulse per sixteenth of a bit time |
| rx_pin | input | 1 | Receive pin level |
| tx_pin | output | 1 | Transmit pin level |
| rx_feed | output | 1 | Serial line handed to the receiver |
| tx_ready | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
The status flags are registered. A write shows up on tx_ready one clock after the strobe edge. The start bit appears and tx_ready recovers one clock later still. tx_empty follows the clock after the final stop-bit tick. The pin routing is combinational, so tx_pin and rx_feed follow rx_pin and chan_mode in the same cycle. The bench drives inputs shortly after each rising edge, advances its behavioural model on that edge, and compares all four outputs against the model at each falling edge, where every registered change is already settled. Directed checks at those same falling edges cover the one-clock ready dip, the overwrite of a pending character and the freeze in remote loopback.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        CH_NORMAL = 2'b00,
        CH_ECHO   = 2'b01,
        CH_LOCAL  = 2'b10,
        CH_REMOTE = 2'b11
    } chan_mode_e;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_st;

    hold_st st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (enable) begin
            if (take) begin
                st_d.full = 1'b0;
            end
            // a write wins over a same-cycle take and replaces any pending byte
            if (wr_en) begin
                st_d.full = 1'b1;
                st_d.data = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full = st_q.full;
    assign data = st_q.data;

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              baud_tick,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_data,
    output logic              take,
    output logic              busy,
    output logic              line
);

    localparam int FRAME_BITS = DATA_W + 2;
    localparam int CNT_W      = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] TICK_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  busy;
        logic [FRAME_BITS-1:0] frame;
        logic [BIT_W-1:0]      bit_cnt;
        logic [CNT_W-1:0]      tick_cnt;
    } shift_st;

    shift_st st_d, st_q;

    assign take = enable && !st_q.busy && load_valid;

    always_comb begin
        st_d = st_q;
        if (enable) begin
            if (st_q.busy) begin
                if (baud_tick) begin
                    if (st_q.tick_cnt == TICK_LAST) begin
                        st_d.tick_cnt = '0;
                        if (st_q.bit_cnt == BIT_LAST) begin
                            st_d.busy = 1'b0;
                        end else begin
                            st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                            st_d.frame   = {1'b1, st_q.frame[FRAME_BITS-1:1]};
                        end
                    end else begin
                        st_d.tick_cnt = st_q.tick_cnt + 1'b1;
                    end
                end
            end else if (load_valid) begin
                st_d.busy     = 1'b1;
                st_d.frame    = {1'b1, load_data, 1'b0};
                st_d.bit_cnt  = '0;
                st_d.tick_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, frame: '1, bit_cnt: '0, tick_cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign line = st_q.busy ? st_q.frame[0] : 1'b1;

endmodule

// File: rtl/uart_tx_route.sv
module uart_tx_route
    import uart_tx_pkg::*;
(
    input  chan_mode_e mode,
    input  logic       tx_line,
    input  logic       rx_pin,
    output logic       tx_pin,
    output logic       rx_feed
);

    always_comb begin
        case (mode)
            CH_NORMAL: begin tx_pin = tx_line; rx_feed = rx_pin;  end
            CH_ECHO:   begin tx_pin = rx_pin;  rx_feed = rx_pin;  end
            CH_LOCAL:  begin tx_pin = 1'b1;    rx_feed = tx_line; end
            default:   begin tx_pin = rx_pin;  rx_feed = 1'b1;    end
        endcase
    end

endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan
    import uart_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        chan_mode,
    input  logic              baud_tick,
    input  logic              rx_pin,
    output logic              tx_pin,
    output logic              rx_feed,
    output logic              tx_ready,
    output logic              tx_empty
);

    chan_mode_e        mode;
    logic              path_en;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              sh_busy;
    logic              tx_line;

    assign mode    = chan_mode_e'(chan_mode);
    assign path_en = (mode != CH_REMOTE);

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (path_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_tx_shift #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (path_en),
        .baud_tick  (baud_tick),
        .load_valid (hold_full),
        .load_data  (hold_data),
        .take       (take),
        .busy       (sh_busy),
        .line       (tx_line)
    );

    uart_tx_route u_route (
        .mode    (mode),
        .tx_line (tx_line),
        .rx_pin  (rx_pin),
        .tx_pin  (tx_pin),
        .rx_feed (rx_feed)
    );

    assign tx_ready = !hold_full;
    assign tx_empty = !hold_full && !sh_busy;

endmodule

// File: rtl/uart_tx_chan_chk.sv
module uart_tx_chan_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] chan_mode,
    input logic       rx_pin,
    input logic       tx_pin,
    input logic       rx_feed,
    input logic       tx_ready,
    input logic       tx_empty
);

    AST_WRITE_FILLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && chan_mode != 2'b11) |=> !tx_ready); // R5

    AST_EMPTY_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_ready); // R6

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mode == 2'b00 && tx_empty) |-> tx_pin); // R3

    AST_LOCAL_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mode == 2'b10) |-> tx_pin); // R9

    AST_REMOTE_WIRING: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mode == 2'b11) |-> (tx_pin == rx_pin && rx_feed)); // R10

    AST_REMOTE_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mode == 2'b11) |=> ($stable(tx_ready) && $stable(tx_empty))); // R10

    AST_ECHO_WIRING: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mode == 2'b01) |-> (tx_pin == rx_pin && rx_feed == rx_pin)); // R8

endmodule

bind uart_tx_chan uart_tx_chan_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .chan_mode (chan_mode),
    .rx_pin    (rx_pin),
    .tx_pin    (tx_pin),
    .rx_feed   (rx_feed),
    .tx_ready  (tx_ready),
    .tx_empty  (tx_empty)
);

// File: tb/tb_uart_tx_chan.sv
module tb_uart_tx_chan;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] chan_mode = 2'b00;
    logic       baud_tick = 1'b0;
    logic       rx_pin = 1'b1;
    logic       tx_pin, rx_feed, tx_ready, tx_empty;

    int n_tests = 0;
    int n_fail  = 0;
    int tick_div = 0;
    bit tick_on = 1'b1;

    // behavioural reference state
    bit       m_hold_full = 1'b0;
    bit [7:0] m_hold_data = 8'h00;
    bit       m_busy = 1'b0;
    int       m_ticks = 0;
    bit [7:0] m_frame = 8'h00;

    always #10 clk = ~clk;

    uart_tx_chan dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .chan_mode(chan_mode), .baud_tick(baud_tick), .rx_pin(rx_pin),
        .tx_pin(tx_pin), .rx_feed(rx_feed), .tx_ready(tx_ready), .tx_empty(tx_empty)
    );

    function automatic bit model_line();
        int idx;
        if (!m_busy) return 1'b1;
        idx = m_ticks / 16;
        if (idx == 0) return 1'b0;
        if (idx <= 8) return m_frame[idx-1];
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (rst_n && chan_mode != 2'b11) begin
            if (m_busy) begin
                if (baud_tick) begin
                    m_ticks++;
                    if (m_ticks == 160) m_busy = 1'b0;
                end
            end else if (m_hold_full) begin
                m_busy = 1'b1;
                m_ticks = 0;
                m_frame = m_hold_data;
                m_hold_full = 1'b0;
            end
            if (wr_en) begin
                m_hold_full = 1'b1;
                m_hold_data = wr_data;
            end
        end
    end

    task automatic check(input bit act, input bit exp, input string tag, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            bit    ln;
            bit    exp_tx;
            bit    exp_rf;
            string tg;
            ln = model_line();
            case (chan_mode)
                2'b00: begin exp_tx = ln;     exp_rf = rx_pin; tg = "R3/R7"; end
                2'b01: begin exp_tx = rx_pin; exp_rf = rx_pin; tg = "R8";    end
                2'b10: begin exp_tx = 1'b1;   exp_rf = ln;     tg = "R9";    end
                default: begin exp_tx = rx_pin; exp_rf = 1'b1; tg = "R10";   end
            endcase
            check(tx_pin, exp_tx, tg, "tx_pin");
            check(rx_feed, exp_rf, tg, "rx_feed");
            check(tx_ready, !m_hold_full, "R2", "tx_ready");
            check(tx_empty, !m_hold_full && !m_busy, "R6", "tx_empty");
        end
    end

    // baud tick every third clock
    always @(posedge clk) begin
        #2;
        tick_div = (tick_div + 1) % 3;
        baud_tick = tick_on && (tick_div == 0);
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic put(input bit [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 4000; i++) begin
            if (tx_empty) return;
            step(1);
        end
        check(1'b0, 1'b1, "R6", "path never drained");
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("[TB] FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(3);
        check(tx_pin, 1'b1, "R1", "reset tx_pin");
        check(tx_ready, 1'b1, "R1", "reset tx_ready");
        check(tx_empty, 1'b1, "R1", "reset tx_empty");
        rst_n = 1'b1;
        step(4);

        // R2: single write into an idle path
        put(8'hA5);
        @(negedge clk);
        check(tx_ready, 1'b0, "R2", "ready low after write");
        check(tx_empty, 1'b0, "R6", "empty low after write");
        step(1);
        @(negedge clk);
        check(tx_ready, 1'b1, "R2", "ready back after load");
        check(tx_pin, 1'b0, "R3", "start bit");
        step(1);
        wait_empty();

        // R4 and R5: second write during a frame, then an overwrite
        put(8'h3C);
        step(3);
        put(8'h81);
        step(40);
        @(negedge clk);
        check(tx_ready, 1'b0, "R4", "ready low while first frame shifts");
        step(1);
        put(8'h7E);
        @(negedge clk);
        check(tx_ready, 1'b0, "R5", "ready low after overwrite");
        step(1);
        wait_empty();

        // R8: echo while transmitting
        chan_mode = 2'b01;
        put(8'h55);
        for (int i = 0; i < 600; i++) begin
            rx_pin = (i % 7) < 3;
            step(1);
        end
        wait_empty();
        rx_pin = 1'b1;

        // R9: local loopback, rx_pin toggling has no effect
        chan_mode = 2'b10;
        put(8'h0F);
        for (int i = 0; i < 600; i++) begin
            rx_pin = (i % 5) == 0;
            step(1);
        end
        wait_empty();
        rx_pin = 1'b1;

        // R10: remote loopback freezes a frame in flight and drops writes
        chan_mode = 2'b00;
        put(8'hC3);
        step(100);
        chan_mode = 2'b11;
        step(1);
        put(8'hFF);
        for (int i = 0; i < 200; i++) begin
            rx_pin = (i % 4) < 2;
            step(1);
        end
        @(negedge clk);
        check(tx_ready, 1'b1, "R10", "write ignored in remote loopback");
        check(tx_empty, 1'b0, "R10", "frame held in remote loopback");
        rx_pin = 1'b1;
        chan_mode = 2'b00;
        step(1);
        wait_empty();
        @(negedge clk);
        check(tx_empty, 1'b1, "R6", "drained after resume");
        check(tx_pin, 1'b1, "R3", "idle line after last stop bit");
        step(5);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule